// File: doc/BRIEF.md
# Prescaled Timer with Modulo Reload

This block keeps time in units of machine ticks. Batches of elapsed ticks arrive on a valid/ready input and are applied one tick per clock cycle to a shared 8-bit tick counter. A free-running 8-bit divider advances once every 64 ticks. An 8-bit up-counter advances at one of four rates. Each rate is taken from a mask over the same tick counter.

When the up-counter passes 0xFF it does not wrap to zero. In the same step it loads the reload value present on its input, and one cycle later it raises a single-cycle interrupt request. A small write port lets software clear the divider (which also clears the tick counter) or load the up-counter directly.

Back-pressure rules for the tick stream:
- A batch is accepted on a clock edge where both `tick_valid` and `tick_ready` are high.
- `tick_ready` stays low until every tick of the accepted batch has been applied.
- The source must hold `tick_n` steady while `tick_valid` is high and `tick_ready` is low.

Top module: `prescaled_timer`

## Requirements
- R1: After reset `div_out` and `cnt_out` are 0x00, `irq_out` is low and `tick_ready` is high.
- R2: A batch of `tick_n` ticks is taken when `tick_valid` and `tick_ready` are both high. It is then applied one tick per cycle in the following cycles. `tick_ready` is low until the last tick is applied, so a batch of 5 holds it low for 5 cycles. A batch of 0 changes nothing.
- R3: `div_out` increases by one each time the tick counter's low six bits return to zero, which is every 64 ticks. This happens whether or not `run_en` is set.
- R4: Each `rate_sel` value gives a counting period, measured from a zeroed tick counter. `rate_sel`=0 counts every 256 ticks, 1 every 4 ticks, 2 every 16 ticks and 3 every 64 ticks.
- R5: While `run_en` is low, `cnt_out` does not advance.
- R6: An increment from 0xFF loads `cnt_out` with the `reload_val` present at that tick instead of 0x00.
- R7: `irq_out` is high for exactly one cycle per overflow, in the cycle after the overflowing tick.
- R8: A write with `wr_sel`=0 clears both the divider and the tick counter. A write with `wr_sel`=1 loads `cnt_out` with `wr_data`.
- R9: Changing `reload_val` after an overflow has no effect on `cnt_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_valid | input | 1 | A tick batch is offered |
| tick_ready | output | 1 | Block can take a new batch |
| tick_n | input | 4 | Number of ticks in the offered batch |
| run_en | input | 1 | Up-counter enable |
| rate_sel | input | 2 | Up-counter rate select |
| reload_val | input | 8 | Value loaded on overflow |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0: clear divider, 1: load up-counter |
| wr_data | input | 8 | Up-counter load value |
| div_out | output | 8 | Divider value |
| cnt_out | output | 8 | Up-counter value |
| irq_out | output | 1 | Single-cycle overflow request |

## Verification
The single-cycle check on `irq_out` relies on the shortest rate period being at least two ticks, which holds for all four rate settings. The check that a taken batch drops `tick_ready` assumes the source keeps `tick_n` constant while it waits. The stimulus drives every input on the falling edge and only offers a batch when `tick_ready` was seen high. It never issues a write while a batch is still draining, so writes and tick steps never overlap.

// File: rtl/timer_pkg.sv
package timer_pkg;

  // shift amount giving the counting period 2**shift for each rate select
  function automatic int unsigned rate_shift(input logic [1:0] sel);
    case (sel)
      2'd0:    return 8;
      2'd1:    return 2;
      2'd2:    return 4;
      default: return 6;
    endcase
  endfunction

  typedef enum logic {
    WSEL_DIV = 1'b0,
    WSEL_CNT = 1'b1
  } wsel_e;

endpackage

// File: rtl/tick_feeder.sv
module tick_feeder #(
  parameter int unsigned N_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick_valid,
  input  logic [N_W-1:0] tick_n,
  output logic           tick_ready,
  output logic           step
);
  logic [N_W-1:0] remain_q;
  logic           take;

  assign tick_ready = (remain_q == '0);
  assign take       = tick_valid && tick_ready;
  assign step       = (remain_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)             remain_q <= '0;
    else if (take)          remain_q <= tick_n;
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && tick_n != '0) |=> !tick_ready);

endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
  import timer_pkg::*;
#(
  parameter int unsigned TICK_W    = 8,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_SHIFT = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             clr,
  input  logic [1:0]       rate_sel,
  output logic [DIV_W-1:0] div_q,
  output logic             rate_hit
);
  logic [TICK_W-1:0] tick_q;
  logic [TICK_W-1:0] tick_nx;
  logic [TICK_W-1:0] mask;
  int unsigned       sh;

  assign tick_nx = tick_q + 1'b1;

  always_comb begin
    sh   = rate_shift(rate_sel);
    mask = TICK_W'((32'd1 << sh) - 32'd1);
  end

  assign rate_hit = step && !clr && ((tick_nx & mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      tick_q <= '0;
      div_q  <= '0;
    end else if (step) begin
      tick_q <= tick_nx;
      if (tick_nx[DIV_SHIFT-1:0] == '0) div_q <= div_q + 1'b1;
    end
  end

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (div_q == '0 && tick_q == '0));

  // R3
  div_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !clr) |=> $stable(div_q));

endmodule

// File: rtl/mod_counter.sv
module mod_counter #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             rate_hit,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             irq_q
);
  localparam logic [CNT_W-1:0] TOP = '1;
  logic inc;

  assign inc = run_en && rate_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= inc && !ld && (cnt_q == TOP);
      if (ld)       cnt_q <= ld_data;
      else if (inc) cnt_q <= (cnt_q == TOP) ? reload_val : cnt_q + 1'b1;
    end
  end

  // R6
  reload_on_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> (cnt_q == $past(reload_val)));

  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |=> !irq_q);

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !ld) |=> $stable(cnt_q));

endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import timer_pkg::*;
#(
  parameter int unsigned N_W       = 4,
  parameter int unsigned TICK_W    = 8,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned DIV_SHIFT = 6,
  parameter int unsigned CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_valid,
  output logic             tick_ready,
  input  logic [N_W-1:0]   tick_n,
  input  logic             run_en,
  input  logic [1:0]       rate_sel,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [DIV_W-1:0] div_out,
  output logic [CNT_W-1:0] cnt_out,
  output logic             irq_out
);
  logic step, clr, ld, hit;

  assign clr = wr_en && (wsel_e'(wr_sel) == WSEL_DIV);
  assign ld  = wr_en && (wsel_e'(wr_sel) == WSEL_CNT);

  tick_feeder #(.N_W(N_W)) u_feed (
    .clk(clk), .rst_n(rst_n), .tick_valid(tick_valid), .tick_n(tick_n),
    .tick_ready(tick_ready), .step(step)
  );

  tick_prescaler #(.TICK_W(TICK_W), .DIV_W(DIV_W), .DIV_SHIFT(DIV_SHIFT)) u_pre (
    .clk(clk), .rst_n(rst_n), .step(step), .clr(clr), .rate_sel(rate_sel),
    .div_q(div_out), .rate_hit(hit)
  );

  mod_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .rate_hit(hit),
    .reload_val(reload_val), .ld(ld), .ld_data(wr_data),
    .cnt_q(cnt_out), .irq_q(irq_out)
  );

endmodule

// File: tb/sim_prescaled_timer.sv
module sim_prescaled_timer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_valid = 1'b0, run_en = 1'b0, wr_en = 1'b0, wr_sel = 1'b0;
  logic [3:0] tick_n = '0;
  logic [1:0] rate_sel = '0;
  logic [7:0] reload_val = '0, wr_data = '0;
  logic tick_ready, irq_out;
  logic [7:0] div_out, cnt_out;

  int errors = 0, checks = 0, irq_seen = 0;

  always #10 clk = ~clk;

  prescaled_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick_valid(tick_valid), .tick_ready(tick_ready),
    .tick_n(tick_n), .run_en(run_en), .rate_sel(rate_sel), .reload_val(reload_val),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .div_out(div_out), .cnt_out(cnt_out), .irq_out(irq_out)
  );

  always @(negedge clk) if (irq_out) irq_seen++;

  typedef struct packed {
    logic [1:0]  sel;
    logic        run;
    logic [7:0]  rel;
    logic [7:0]  pre;
    logic [15:0] ticks;
    logic [7:0]  ecnt;
    logic [7:0]  ediv;
    logic [3:0]  eirq;
  } vec_t;

  // rate/period, enable, reload, preload, ticks -> expected counter, divider, irqs
  localparam vec_t VEC [6] = '{
    '{2'd1, 1'b1, 8'h00, 8'h10, 16'd40,  8'h1A, 8'd0, 4'd0},
    '{2'd2, 1'b1, 8'h80, 8'hFE, 16'd48,  8'h81, 8'd0, 4'd1},
    '{2'd3, 1'b1, 8'h00, 8'h05, 16'd200, 8'h08, 8'd3, 4'd0},
    '{2'd0, 1'b1, 8'h42, 8'hFF, 16'd300, 8'h42, 8'd4, 4'd1},
    '{2'd1, 1'b0, 8'h00, 8'h33, 16'd100, 8'h33, 8'd1, 4'd0},
    '{2'd1, 1'b1, 8'hFD, 8'hFE, 16'd20,  8'hFD, 8'd0, 4'd2}
  };

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic feed(input int total);
    int left = total;
    while (left > 0) begin
      int b = (left > 15) ? 15 : left;
      @(negedge clk);
      while (!tick_ready) @(negedge clk);
      tick_valid = 1'b1; tick_n = 4'(b);
      @(negedge clk);
      tick_valid = 1'b0;
      left -= b;
    end
    while (!tick_ready) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 div", div_out, 0);
    chk("R1 cnt", cnt_out, 0);
    chk("R1 irq", irq_out, 0);
    chk("R1 ready", tick_ready, 1);

    // table: R3 R4 R5 R6 R7
    for (int i = 0; i < 6; i++) begin
      int base;
      run_en = 1'b0;
      wr(1'b0, 8'h00);
      wr(1'b1, VEC[i].pre);
      rate_sel = VEC[i].sel; run_en = VEC[i].run; reload_val = VEC[i].rel;
      base = irq_seen;
      feed(int'(VEC[i].ticks));
      chk("R4/R5/R6 cnt", cnt_out, VEC[i].ecnt);
      chk("R3 div", div_out, VEC[i].ediv);
      chk("R7 irq count", irq_seen - base, VEC[i].eirq);
    end

    // R8 counter load
    run_en = 1'b0;
    wr(1'b1, 8'h5A);
    chk("R8 cnt load", cnt_out, 8'h5A);

    // R8 divider clear also zeroes the tick counter
    feed(100);
    chk("R3 div", div_out, 1);
    wr(1'b0, 8'h00);
    chk("R8 div clear", div_out, 0);
    feed(63);
    chk("R8 tick counter cleared", div_out, 0);
    feed(1);
    chk("R3 div after 64", div_out, 1);

    // R2 back-pressure
    @(negedge clk);
    tick_valid = 1'b1; tick_n = 4'd5;
    @(negedge clk);
    tick_valid = 1'b0;
    chk("R2 ready low", tick_ready, 0);
    begin
      int busy = 0;
      while (!tick_ready && busy < 50) begin @(negedge clk); busy++; end
      chk("R2 busy cycles", busy, 5);
    end
    // R2 empty batch
    wr(1'b0, 8'h00);
    feed(63);
    @(negedge clk);
    tick_valid = 1'b1; tick_n = 4'd0;
    @(negedge clk);
    tick_valid = 1'b0;
    chk("R2 zero batch ready", tick_ready, 1);
    repeat (2) @(negedge clk);
    chk("R2 zero batch div", div_out, 0);

    // R9 reload sampled at overflow only
    wr(1'b0, 8'h00);
    wr(1'b1, 8'hFF);
    rate_sel = 2'd1; run_en = 1'b1; reload_val = 8'h11;
    feed(4);
    chk("R6 reload", cnt_out, 8'h11);
    reload_val = 8'h99;
    repeat (3) @(negedge clk);
    chk("R9 reload change ignored", cnt_out, 8'h11);
    feed(4);
    chk("R9 next count", cnt_out, 8'h12);

    // R1 reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cnt after reset", cnt_out, 0);
    chk("R1 div after reset", div_out, 0);
    chk("R1 ready after reset", tick_ready, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule